// File: doc/BRIEF.md
# Router Power-Gating State Controller

This block decides, cycle by cycle, whether one on-chip router is powered, gated off, or coming back up. It gates the router off after its datapath has stayed empty for a short run of cycles. It brings the router back only when demand from the local network interface justifies it. Demand is measured as the number of virtual-channel request pulses seen in a sliding window of recent cycles. That count is compared with a threshold chosen by a static class input. A performance-centric router uses a low threshold and returns to service early. A power-centric router uses a high threshold and stays dark longer.

While the router is off or waking, the block raises a bypass flag. The datapath then sends packets over the bypass paths, so the node never loses its connection and the wakeup delay stays off the packet path. The block also keeps a saturating count of off periods that ended before the break-even time, so that wasted gating events can be observed. The power switch and the bypass datapath themselves lie outside this block.

Top module: `rtr_pwr_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after release, the block is in the powered state: `ready_o`=1, `bypass_o`=0, `pg_en_o`=0 and `short_off_cnt_o`=0.
- R2: From the powered state, the block gates off at the clock edge that samples the IDLE_CYC-th consecutive cycle with `dp_empty_i`=1 (default 4), but only if the request rate at that edge does not exceed the active threshold. Any cycle with `dp_empty_i`=0 restarts the run.
- R3: The request rate is the number of cycles with `vc_req_i`=1 among the last WIN_LEN sampled cycles (default 16). A pulse older than WIN_LEN cycles no longer counts.
- R4: From the off state, the block moves to waking at the edge where the rate strictly exceeds the threshold. The threshold is THR_PERF (default 2) when `perf_class_i`=1 and THR_PWR (default 6) when `perf_class_i`=0. A rate equal to the threshold does not wake it.
- R5: The waking state lasts exactly WAKE_CYC cycles (default 12), after which the block returns to the powered state.
- R6: The output encoding is as follows. Powered: `ready_o`=1, `bypass_o`=0, `pg_en_o`=0. Off: `ready_o`=0, `bypass_o`=1, `pg_en_o`=1. Waking: `ready_o`=0, `bypass_o`=1, `pg_en_o`=0.
- R7: In the off state `dp_empty_i` has no effect. In the waking state neither `dp_empty_i` nor `vc_req_i` has any effect on the state. The off state is never left directly to the powered state.
- R8: When an off period lasting fewer than BET_CYC cycles (default 10) ends, `short_off_cnt_o` increments by one. It saturates at its all-ones value (default width 4, so 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dp_empty_i | input | 1 | Router datapath holds no flits this cycle |
| vc_req_i | input | 1 | One VC request from the local network interface this cycle |
| perf_class_i | input | 1 | 1 = performance-centric router, 0 = power-centric router |
| pg_en_o | output | 1 | Power switch open (router supply cut) |
| ready_o | output | 1 | Router powered and usable |
| bypass_o | output | 1 | Datapath must route through the bypass paths |
| short_off_cnt_o | output | SHORT_W | Saturating count of off periods shorter than the break-even time |

## Verification
A wrong window count shows up as a change of `pg_en_o` at the wrong edge. It also shows up in the idle decision, since a too-high rate blocks gating. A stale pulse that is never retired keeps an off router waking at once. A wrong wake timer shows `ready_o` one or more cycles early or late after exactly WAKE_CYC waking cycles. A wrong break-even comparison shows `short_off_cnt_o` stepping on the wrong off period. Because every output comes straight from registered state, each of these faults is visible on the cycle right after the edge that took the wrong decision. A cycle-exact reference model therefore flags it within one clock.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  typedef enum logic [1:0] {
    PS_ON   = 2'd0,
    PS_OFF  = 2'd1,
    PS_WAKE = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/rpg_rate_win.sv
module rpg_rate_win #(
  parameter int WIN_LEN  = 16,
  parameter int THR_PERF = 2,
  parameter int THR_PWR  = 6,
  localparam int CW      = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          perf_i,
  output logic [CW-1:0] rate_o,
  output logic          above_o
);

  logic [WIN_LEN-1:0] hist_q, hist_d;
  logic [CW-1:0]      rate_q, rate_d;
  logic               oldest;
  int                 thr;

  generate
    if (WIN_LEN == 1) begin : g_one
      always_comb hist_d = req_i;
    end else begin : g_many
      always_comb hist_d = {hist_q[WIN_LEN-2:0], req_i};
    end
  endgenerate

  always_comb begin
    oldest = hist_q[WIN_LEN-1];
    rate_d = rate_q + CW'(req_i) - CW'(oldest);
    thr    = perf_i ? THR_PERF : THR_PWR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      rate_q <= '0;
    end else begin
      hist_q <= hist_d;
      rate_q <= rate_d;
    end
  end

  assign rate_o  = rate_q;
  assign above_o = int'(rate_q) > thr;

  // R3
  rate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rate_q) <= WIN_LEN);

  // R3
  rate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == $past(rate_q)) || (rate_q == $past(rate_q) + 1'b1) ||
    (rate_q + 1'b1 == $past(rate_q)));

endmodule

// File: rtl/rpg_idle_det.sv
module rpg_idle_det #(
  parameter int IDLE_CYC = 4,
  localparam int IW      = $clog2(IDLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic track_i,
  input  logic empty_i,
  output logic idle_done_o
);

  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYC);
  localparam logic [IW-1:0] IDLE_M1  = IW'(IDLE_CYC - 1);

  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  always_comb begin
    idle_d  = idle_q;
    idle_en = 1'b0;
    if (!track_i || !empty_i) begin
      idle_en = (idle_q != '0);
      idle_d  = '0;
    end else if (idle_q < IDLE_MAX) begin
      idle_en = 1'b1;
      idle_d  = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  assign idle_done_o = track_i && empty_i && (idle_q >= IDLE_M1);

  // R2
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(empty_i) |-> idle_q == '0);

endmodule

// File: rtl/rpg_fsm.sv
module rpg_fsm
  import rpg_pkg::*;
#(
  parameter int WAKE_CYC = 12,
  parameter int BET_CYC  = 10,
  localparam int WW      = $clog2(WAKE_CYC + 1),
  localparam int OW      = $clog2(BET_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_done_i,
  input  logic       above_i,
  output pwr_state_e state_o,
  output logic       short_end_o
);

  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CYC - 1);
  localparam logic [OW-1:0] OFF_SAT   = OW'(BET_CYC);
  localparam logic [OW-1:0] BET_M1    = OW'(BET_CYC - 1);

  pwr_state_e    state_q, state_d;
  logic [WW-1:0] wake_q, wake_d;
  logic [OW-1:0] off_q, off_d;
  logic          wake_en, off_en;

  always_comb begin
    state_d     = state_q;
    wake_d      = wake_q;
    off_d       = off_q;
    wake_en     = 1'b0;
    off_en      = 1'b0;
    short_end_o = 1'b0;
    case (state_q)
      PS_ON: begin
        if (idle_done_i && !above_i) begin
          state_d = PS_OFF;
          off_d   = '0;
          off_en  = 1'b1;
        end
      end
      PS_OFF: begin
        if (off_q < OFF_SAT) begin
          off_d  = off_q + 1'b1;
          off_en = 1'b1;
        end
        if (above_i) begin
          state_d     = PS_WAKE;
          wake_d      = WAKE_LOAD;
          wake_en     = 1'b1;
          short_end_o = (off_q < BET_M1);
        end
      end
      PS_WAKE: begin
        if (wake_q == '0) begin
          state_d = PS_ON;
        end else begin
          wake_d  = wake_q - 1'b1;
          wake_en = 1'b1;
        end
      end
      default: state_d = PS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_ON;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= '0;
    else if (wake_en) wake_q <= wake_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign state_o = state_q;

  // R2
  gate_off_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF && $past(state_q) == PS_ON) |-> $past(idle_done_i && !above_i));

  // R4
  wake_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAKE && $past(state_q) == PS_OFF) |-> $past(above_i));

  // R5
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ON && $past(state_q) == PS_WAKE) |-> $past(wake_q) == '0);

  // R7
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PS_OFF |=> state_q != PS_ON);

endmodule

// File: rtl/rpg_short_cnt.sv
module rpg_short_cnt #(
  parameter int SHORT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  output logic [SHORT_W-1:0] cnt_o
);

  logic [SHORT_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = inc_i && (cnt_q != '1);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != $past(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1) && $past(inc_i));

endmodule

// File: rtl/rtr_pwr_ctrl.sv
module rtr_pwr_ctrl
  import rpg_pkg::*;
#(
  parameter int WIN_LEN  = 16,
  parameter int THR_PERF = 2,
  parameter int THR_PWR  = 6,
  parameter int IDLE_CYC = 4,
  parameter int WAKE_CYC = 12,
  parameter int BET_CYC  = 10,
  parameter int SHORT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dp_empty_i,
  input  logic               vc_req_i,
  input  logic               perf_class_i,
  output logic               pg_en_o,
  output logic               ready_o,
  output logic               bypass_o,
  output logic [SHORT_W-1:0] short_off_cnt_o
);

  localparam int CW = $clog2(WIN_LEN + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic [CW-1:0] rate;
  logic          above;
  logic          idle_done;
  logic          short_end;
  pwr_state_e    state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  rpg_rate_win #(
    .WIN_LEN (WIN_LEN),
    .THR_PERF(THR_PERF),
    .THR_PWR (THR_PWR)
  ) u_rate (
    .clk    (clk),
    .rst_n  (rst_sn),
    .req_i  (vc_req_i),
    .perf_i (perf_class_i),
    .rate_o (rate),
    .above_o(above)
  );

  rpg_idle_det #(
    .IDLE_CYC(IDLE_CYC)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_sn),
    .track_i    (state == PS_ON),
    .empty_i    (dp_empty_i),
    .idle_done_o(idle_done)
  );

  rpg_fsm #(
    .WAKE_CYC(WAKE_CYC),
    .BET_CYC (BET_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .idle_done_i(idle_done),
    .above_i    (above),
    .state_o    (state),
    .short_end_o(short_end)
  );

  rpg_short_cnt #(
    .SHORT_W(SHORT_W)
  ) u_short (
    .clk  (clk),
    .rst_n(rst_sn),
    .inc_i(short_end),
    .cnt_o(short_off_cnt_o)
  );

  assign pg_en_o  = (state == PS_OFF);
  assign ready_o  = (state == PS_ON);
  assign bypass_o = (state != PS_ON);

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ready_o) |-> $past(bypass_o) && !$past(pg_en_o));

  // R2
  gate_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pg_en_o) |-> $past(dp_empty_i));

endmodule

// File: tb/rtr_pwr_ctrl_tb.sv
module rtr_pwr_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN    = 16;
  localparam int TPERF  = 2;
  localparam int TPWR   = 6;
  localparam int IDLE   = 4;
  localparam int WAKE   = 12;
  localparam int BET    = 10;
  localparam int SW     = 4;
  localparam int M_ON   = 0;
  localparam int M_OFF  = 1;
  localparam int M_WAKE = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dp_empty = 1'b0;
  logic          vc_req = 1'b0;
  logic          perf = 1'b0;
  logic          pg_en, ready, bypass;
  logic [SW-1:0] short_cnt;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    started = 1'b0;
  string phase = "R1";

  int m_state = M_ON;
  int m_idle  = 0;
  int m_off   = 0;
  int m_wake  = 0;
  int m_short = 0;
  int m_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtr_pwr_ctrl u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .dp_empty_i     (dp_empty),
    .vc_req_i       (vc_req),
    .perf_class_i   (perf),
    .pg_en_o        (pg_en),
    .ready_o        (ready),
    .bypass_o       (bypass),
    .short_off_cnt_o(short_cnt)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (started) begin
      int rate;
      int thr;
      rate = 0;
      foreach (m_hist[i]) rate += m_hist[i];
      thr = perf ? TPERF : TPWR;
      case (m_state)
        M_ON: begin
          m_idle = dp_empty ? m_idle + 1 : 0;
          if (m_idle >= IDLE && rate <= thr) begin
            m_state = M_OFF;
            m_off   = 0;
            m_idle  = 0;
          end
        end
        M_OFF: begin
          m_off++;
          if (rate > thr) begin
            if (m_off < BET && m_short < (1 << SW) - 1) m_short++;
            m_state = M_WAKE;
            m_wake  = 0;
          end
        end
        default: begin
          m_wake++;
          if (m_wake == WAKE) m_state = M_ON;
        end
      endcase
      m_hist.push_back(vc_req ? 1 : 0);
      if (m_hist.size() > WIN) void'(m_hist.pop_front());
    end
  end

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic check_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model (R6 encoding)
  always @(negedge clk) begin
    cycles++;
    if (started) begin
      check_bit({phase, "/R6"}, "ready_o", ready, m_state == M_ON);
      check_bit({phase, "/R6"}, "bypass_o", bypass, m_state != M_ON);
      check_bit({phase, "/R6"}, "pg_en_o", pg_en, m_state == M_OFF);
      check_int({phase, "/R8"}, "short_off_cnt_o", int'(short_cnt), m_short);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(bit e, bit r);
    dp_empty = e;
    vc_req   = r;
    @(negedge clk);
  endtask

  task automatic expect_state(string req, int st);
    check_bit(req, "ready_o", ready, st == M_ON);
    check_bit(req, "bypass_o", bypass, st != M_ON);
    check_bit(req, "pg_en_o", pg_en, st == M_OFF);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    expect_state("R1", M_ON);
    check_int("R1", "short_off_cnt_o", int'(short_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1", M_ON);
    repeat (3) @(negedge clk);
    started = 1'b1;

    // R2: bubbles restart the idle run
    phase = "R2";
    perf  = 1'b0;
    repeat (2) begin
      repeat (3) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    expect_state("R2", M_ON);
    repeat (3) step(1'b1, 1'b0);
    expect_state("R2", M_ON);
    step(1'b1, 1'b0);
    expect_state("R2", M_OFF);

    // R7 / R4: empty toggles ignored in OFF; rate equal to threshold holds
    phase = "R4";
    for (int k = 0; k < 6; k++) begin
      step(k[0], 1'b1);
      step(~k[0], 1'b0);
    end
    expect_state("R7", M_OFF);
    expect_state("R4", M_OFF);
    step(1'b0, 1'b1);
    expect_state("R4", M_OFF);
    step(1'b0, 1'b0);
    expect_state("R4", M_WAKE);
    check_int("R8", "long off not counted", int'(short_cnt), 0);

    // R5 / R7: waking lasts WAKE cycles regardless of inputs
    phase = "R5";
    for (int k = 0; k < WAKE - 1; k++) step(k[0], 1'b1);
    expect_state("R7", M_WAKE);
    step(1'b1, 1'b0);
    expect_state("R5", M_ON);

    // R2: high rate blocks gating off
    phase = "R2";
    repeat (4) step(1'b1, 1'b0);
    expect_state("R2", M_ON);
    for (int k = 0; k < 40 && !pg_en; k++) step(1'b1, 1'b0);
    expect_state("R2", M_OFF);
    repeat (WIN) step(1'b0, 1'b0);
    expect_state("R2", M_OFF);

    // R3: sparse pulses age out of the window
    phase = "R3";
    perf  = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b1);
      repeat (8) step(1'b0, 1'b0);
    end
    expect_state("R3", M_OFF);
    for (int k = 0; k < 6 && !bypass == 1'b0 && pg_en; k++) begin
      step(1'b0, 1'b1);
      repeat (4) step(1'b0, 1'b0);
    end
    check_bit("R3", "woke on dense pulses", pg_en, 1'b0);

    // R8: many short off periods, counter saturates
    phase = "R8";
    for (int n = 0; n < 18; n++) begin
      for (int k = 0; k < 80 && !pg_en; k++) step(1'b1, 1'b0);
      repeat (3) step(1'b1, 1'b1);
      for (int k = 0; k < 5 && pg_en; k++) step(1'b1, 1'b0);
      if (n == 0) check_int("R8", "first short off", int'(short_cnt), 1);
    end
    check_int("R8", "saturated count", int'(short_cnt), (1 << SW) - 1);
    repeat (20) step(1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule